// File: doc/BRIEF.md
# Register-Driven I2C Byte Master

This block is an I2C master that software steers through one 8-bit control register. All bus conditions come from register writes. Setting the master bit produces a START. Clearing it produces a STOP. A self-clearing request bit produces a repeated START. Each write to the data register moves one byte across the bus, followed by a ninth acknowledge clock. When the byte completes, a flag is raised and an interrupt line can be asserted.

SCL and SDA are open-drain. The block only ever pulls a line low (`*_oe` = 1) or releases it, and it reads the wired bus back through synchronizers. In transmit mode it compares the level it released against the level on the bus. If another device holds SDA low while the block has released it, the block gives up the bus: it clears the master bit, sends no STOP, and raises an arbitration-loss flag. Bus timing comes from a quarter-bit divider set by a parameter.

Register map (`addr`):
- 0 is control. Bit 7 enable, bit 6 interrupt enable, bit 5 master, bit 4 transmit, bit 3 acknowledge level, bit 2 repeated-START request. Bits 2..0 read 0.
- 1 is data. A write loads the byte to send; a read returns the last byte shifted in.
- 2 is status. Bit 7 byte complete, bit 6 arbitration lost; both are cleared by writing 1. Bit 0 is the level sampled in the last acknowledge slot.

Top module: `i2c_regmaster`

## Requirements
- R1: After reset the control and status registers read 0x00, SCL and SDA are released (`scl_oe`=`sda_oe`=0) and `irq` is 0.
- R2: Control bits 7..3 read back as written; bits 2..0 always read 0, including the repeated-START bit (bit 2) after a write of 1.
- R3: Writing control bit 5 from 0 to 1 while bit 7 is 1 makes exactly one START (SDA falls while SCL is high) and the block becomes bus master.
- R4: Writing control bit 5 from 1 to 0 while master makes exactly one STOP (SDA rises while SCL is high); afterwards both lines are released and bit 5 reads 0.
- R5: With bit 4 = 1, a data write shifts the byte out MSB first on 8 SCL pulses, then releases SDA for a ninth pulse and stores the sampled acknowledge level in status bit 0. SDA never changes while SCL is high during the byte.
- R6: With bit 4 = 0, a data write clocks in 8 bits MSB first, which are then returned by a data read. In the ninth slot the block drives the level of control bit 3: 0 pulls SDA low (ACK), 1 leaves it released (NACK).
- R7: Writing control bit 2 = 1 while master and between bytes produces one repeated START and no STOP; bit 2 reads back 0.
- R8: Writing control bit 2 = 1 while not master, or while a byte is in progress, sets status bit 6 and produces no START.
- R9: If SDA reads low during a transmitted data bit that the block released, the block sets status bit 6, clears control bit 5, releases both lines and produces no STOP.
- R10: Status bit 7 is set when a byte completes. `irq` equals control bit 6 AND (status bit 7 OR status bit 6). Writing 1 to a status bit clears it.
- R11: While control bit 7 is 0, both lines stay released and writes of 1 to bits 5 and 2 have no effect: bit 5 reads 0 and no START appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select (0 control, 1 data, 2 status) |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the register at `addr` (combinational) |
| scl_in | input | 1 | SCL level seen on the bus |
| sda_in | input | 1 | SDA level seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `QTR_CYC` = 3 and `SYNC_STAGES` = 2. This gives a 12-cycle bit, so a full byte with its acknowledge, a repeated START and an arbitration abort each fit in a short directed test. It also places the synchronizer delay close to the sample point, which tests that sampling still sees settled data. A bus model in the bench acts as the slave. It can ACK, NACK, supply a byte, or jam SDA low, and it counts START and STOP events on the wired lines.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   localparam int REG_AW = 2;
   localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
   localparam logic [REG_AW-1:0] A_DATA = 2'd1;
   localparam logic [REG_AW-1:0] A_STAT = 2'd2;

   localparam int C_EN   = 7;
   localparam int C_IE   = 6;
   localparam int C_MST  = 5;
   localparam int C_TX   = 4;
   localparam int C_TXAK = 3;
   localparam int C_RS   = 2;

   localparam int S_DONE = 7;
   localparam int S_ARB  = 6;

   typedef enum logic [2:0] {
      E_IDLE, E_START, E_HOLD, E_BIT, E_STOP, E_RSTART
   } eng_state_e;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
   parameter int QTR_CYC = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = $clog2(QTR_CYC + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt <= '0;
      else if (!en || tick)               cnt <= '0;
      else                                cnt <= cnt + 1'b1;
   end

   assign tick = en && (cnt == CW'(QTR_CYC - 1));
endmodule

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES:0] ch;
         assign ch[0] = d;
         for (genvar i = 0; i < STAGES; i++) begin : g_ff
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) ch[i+1] <= 1'b1;
               else        ch[i+1] <= ch[i];
            end
         end
         assign q = ch[STAGES];
      end
   endgenerate
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
   import i2cm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  logic       mst,
   input  logic       tx,
   input  logic       txak,
   input  logic       go,
   input  logic       rs,
   input  logic       abort,
   input  logic [7:0] tx_byte,
   input  logic       scl_s,
   input  logic       sda_s,
   output logic       scl_lo,
   output logic       sda_lo,
   output logic       in_hold,
   output logic       go_take,
   output logic       rs_take,
   output logic       byte_done,
   output logic       arb_lost,
   output logic [7:0] rx_byte,
   output logic       ack_seen
);
   eng_state_e st;
   logic [1:0] q;
   logic [3:0] bcnt;
   logic [7:0] sh;
   logic       bit_val;

   always_comb begin
      if (bcnt < 4'd8) bit_val = tx ? sh[7] : 1'b1;
      else             bit_val = tx ? 1'b1  : txak;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= E_IDLE; q <= '0; bcnt <= '0; sh <= '0; ack_seen <= 1'b0;
         scl_lo <= 1'b0; sda_lo <= 1'b0;
         go_take <= 1'b0; rs_take <= 1'b0; byte_done <= 1'b0; arb_lost <= 1'b0;
      end else begin
         go_take <= 1'b0; rs_take <= 1'b0; byte_done <= 1'b0; arb_lost <= 1'b0;
         if (!en || abort) begin
            st <= E_IDLE; q <= '0; bcnt <= '0;
            scl_lo <= 1'b0; sda_lo <= 1'b0;
         end else if (tick) begin
            case (st)
               E_IDLE: if (mst && scl_s && sda_s) begin
                  sda_lo <= 1'b1;
                  st     <= E_START;
               end
               E_START: begin
                  scl_lo <= 1'b1;
                  st     <= E_HOLD;
               end
               E_HOLD: begin
                  q <= '0;
                  if (!mst) begin
                     sda_lo <= 1'b1; st <= E_STOP;
                  end else if (rs) begin
                     sda_lo <= 1'b0; st <= E_RSTART; rs_take <= 1'b1;
                  end else if (go) begin
                     sh <= tx_byte; bcnt <= '0; st <= E_BIT; go_take <= 1'b1;
                  end
               end
               E_BIT: begin
                  q <= q + 2'd1;
                  case (q)
                     2'd0: sda_lo <= ~bit_val;
                     2'd1: scl_lo <= 1'b0;
                     2'd2: begin
                        if (bcnt < 4'd8) sh <= {sh[6:0], sda_s};
                        else             ack_seen <= sda_s;
                        if (bcnt < 4'd8 && tx && !sda_lo && !sda_s) begin
                           arb_lost <= 1'b1; st <= E_IDLE; q <= '0;
                           scl_lo <= 1'b0; sda_lo <= 1'b0;
                        end
                     end
                     default: begin
                        scl_lo <= 1'b1;
                        if (bcnt == 4'd8) begin
                           st <= E_HOLD; byte_done <= 1'b1;
                        end else begin
                           bcnt <= bcnt + 4'd1;
                        end
                     end
                  endcase
               end
               E_STOP: begin
                  q <= q + 2'd1;
                  if (q == 2'd0) scl_lo <= 1'b0;
                  else begin sda_lo <= 1'b0; st <= E_IDLE; end
               end
               default: begin
                  q <= q + 2'd1;
                  if (q == 2'd0)      scl_lo <= 1'b0;
                  else if (q == 2'd1) sda_lo <= 1'b1;
                  else begin scl_lo <= 1'b1; st <= E_HOLD; end
               end
            endcase
         end
      end
   end

   assign in_hold = (st == E_HOLD);
   assign rx_byte = sh;

   a_r11_lines_free_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!scl_lo && !sda_lo));
   a_r5_sda_moves_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_BIT && !$stable(sda_lo)) |-> $past(scl_lo));
   a_r5_bit_index_range: assert property (@(posedge clk) disable iff (!rst_n)
      bcnt <= 4'd8);
endmodule

// File: rtl/i2c_regmaster.sv
module i2c_regmaster
   import i2cm_pkg::*;
#(
   parameter int QTR_CYC     = 125,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  addr,
   input  logic        wr_en,
   input  logic [7:0]  wdata,
   output logic [7:0]  rdata,
   input  logic        scl_in,
   input  logic        sda_in,
   output logic        scl_oe,
   output logic        sda_oe,
   output logic        irq
);
   generate
      if (QTR_CYC <= SYNC_STAGES) begin : g_bad_timing
         $error("QTR_CYC must exceed SYNC_STAGES");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   logic en_q, ie_q, mst_q, tx_q, txak_q;
   logic go_q, rs_q, abort_q, done_f, arb_f;
   logic [7:0] tx_byte;
   logic tick, scl_s, sda_s;
   logic in_hold, go_take, rs_take, byte_done, arb_lost, ack_seen;
   logic [7:0] rx_byte;
   logic wr_ctrl, wr_data, wr_stat, rs_ok;

   assign wr_ctrl = wr_en && (addr == A_CTRL);
   assign wr_data = wr_en && (addr == A_DATA);
   assign wr_stat = wr_en && (addr == A_STAT);
   assign rs_ok   = mst_q && in_hold && !go_q;

   i2cm_tick #(.QTR_CYC(QTR_CYC)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick));
   i2cm_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
   i2cm_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

   i2cm_engine u_eng (
      .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick), .mst(mst_q),
      .tx(tx_q), .txak(txak_q), .go(go_q), .rs(rs_q), .abort(abort_q),
      .tx_byte(tx_byte), .scl_s(scl_s), .sda_s(sda_s),
      .scl_lo(scl_oe), .sda_lo(sda_oe), .in_hold(in_hold),
      .go_take(go_take), .rs_take(rs_take), .byte_done(byte_done),
      .arb_lost(arb_lost), .rx_byte(rx_byte), .ack_seen(ack_seen));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0; ie_q <= 1'b0; mst_q <= 1'b0; tx_q <= 1'b0; txak_q <= 1'b0;
         go_q <= 1'b0; rs_q <= 1'b0; abort_q <= 1'b0; done_f <= 1'b0; arb_f <= 1'b0;
         tx_byte <= '0;
      end else begin
         abort_q <= 1'b0;
         if (go_take) go_q <= 1'b0;
         if (rs_take) rs_q <= 1'b0;
         if (wr_ctrl) begin
            en_q   <= wdata[C_EN];
            ie_q   <= wdata[C_IE];
            tx_q   <= wdata[C_TX];
            txak_q <= wdata[C_TXAK];
            mst_q  <= wdata[C_EN] && wdata[C_MST];
            if (!wdata[C_EN]) begin
               go_q <= 1'b0; rs_q <= 1'b0;
            end else if (wdata[C_RS]) begin
               if (rs_ok) rs_q <= 1'b1;
               else begin
                  arb_f <= 1'b1; mst_q <= 1'b0; abort_q <= mst_q;
               end
            end
         end
         if (wr_data) begin
            tx_byte <= wdata;
            if (en_q && mst_q) go_q <= 1'b1;
         end
         if (wr_stat) begin
            if (wdata[S_DONE]) done_f <= 1'b0;
            if (wdata[S_ARB])  arb_f  <= 1'b0;
         end
         if (byte_done) done_f <= 1'b1;
         if (arb_lost) begin
            arb_f <= 1'b1; mst_q <= 1'b0;
         end
      end
   end

   always_comb begin
      case (addr)
         A_CTRL:  rdata = {en_q, ie_q, mst_q, tx_q, txak_q, 3'b000};
         A_DATA:  rdata = rx_byte;
         A_STAT:  rdata = {done_f, arb_f, 5'b00000, ack_seen};
         default: rdata = 8'h00;
      endcase
   end

   assign irq = ie_q && (done_f || arb_f);

   a_r10_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && ie_q && !wr_en) |=> irq);
   a_r9_arb_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |=> !mst_q);
   a_r11_no_master_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !mst_q);
endmodule

// File: tb/i2c_regmaster_bench.sv
module i2c_regmaster_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] addr = 2'd0;
   logic wr_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic scl_oe, sda_oe, irq;
   logic scl_bus, sda_bus, slv_sda;

   int n_run = 0;
   int n_fail = 0;
   int start_cnt = 0;
   int stop_cnt = 0;
   int bcf = 0;
   int mode = 0;
   logic [7:0] sbyte = 8'h00;
   logic [15:0] cap = '0;

   always #5 clk = ~clk;

   assign scl_bus = ~scl_oe;
   assign sda_bus = ~sda_oe & slv_sda;

   always_comb begin
      case (mode)
         1:       slv_sda = (bcf == 8) ? 1'b0 : 1'b1;
         2:       slv_sda = (bcf < 8) ? sbyte[7 - bcf] : 1'b1;
         3:       slv_sda = 1'b0;
         default: slv_sda = 1'b1;
      endcase
   end

   always @(negedge scl_bus) bcf <= bcf + 1;
   always @(posedge scl_bus) cap <= {cap[14:0], sda_bus};
   always @(negedge sda_bus) if (scl_bus === 1'b1) start_cnt++;
   always @(posedge sda_bus) if (scl_bus === 1'b1) stop_cnt++;

   i2c_regmaster #(.QTR_CYC(3), .SYNC_STAGES(2)) u_i2c_regmaster (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .rdata(rdata), .scl_in(scl_bus), .sda_in(sda_bus),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk); addr = a; #1; v = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_done();
      logic [7:0] s;
      for (int i = 0; i < 3000; i++) begin
         rd(2'd2, s);
         if (s[7] || s[6]) return;
      end
      chk(1'b0, "byte completion timeout", 0, 1);
   endtask

   task automatic byte_xfer(input int m, input logic [7:0] sb, input logic [7:0] d);
      mode = m; sbyte = sb; bcf = 0; cap = '0;
      wr(2'd1, d);
      wait_done();
      idle(4);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(2'd0, v); chk(v == 8'h00, "R1 ctrl", v, 0);
      rd(2'd2, v); chk(v == 8'h00, "R1 status", v, 0);
      chk(!scl_oe && !sda_oe && !irq, "R1 lines/irq", {scl_oe, sda_oe, irq}, 0);
   endtask

   task automatic t_disabled();
      logic [7:0] v;
      int s0 = start_cnt;
      wr(2'd0, 8'h5F);
      rd(2'd0, v); chk(v == 8'h58, "R2 readback low bits zero", v, 8'h58);
      wr(2'd0, 8'h24);
      idle(60);
      rd(2'd0, v); chk(v == 8'h00, "R11 master ignored when off", v, 0);
      chk(start_cnt == s0 && !scl_oe && !sda_oe, "R11 no START, released", start_cnt - s0, 0);
   endtask

   task automatic t_start();
      logic [7:0] v;
      int s0;
      wr(2'd0, 8'h90); idle(20);
      s0 = start_cnt;
      wr(2'd0, 8'hB0); idle(40);
      chk(start_cnt == s0 + 1, "R3 one START", start_cnt - s0, 1);
      rd(2'd0, v); chk(v == 8'hB0, "R3 master bit", v, 8'hB0);
   endtask

   task automatic t_tx();
      logic [7:0] v;
      int s0 = start_cnt, p0 = stop_cnt;
      byte_xfer(1, 8'h00, 8'hA5);
      chk(cap[8:1] == 8'hA5, "R5 byte on bus MSB first", cap[8:1], 8'hA5);
      rd(2'd2, v); chk(v == 8'h80, "R5 ack sampled 0, done set", v, 8'h80);
      chk(start_cnt == s0 && stop_cnt == p0, "R5 SDA steady while SCL high",
          start_cnt + stop_cnt - s0 - p0, 0);
      chk(irq == 1'b0, "R10 irq masked", irq, 0);
      wr(2'd0, 8'hF0);
      chk(irq == 1'b1, "R10 irq on enable", irq, 1);
      wr(2'd2, 8'hC0);
      rd(2'd2, v); chk(v[7] == 1'b0 && irq == 1'b0, "R10 write-1 clear", {v[7], irq}, 0);
      byte_xfer(0, 8'h00, 8'h5A);
      rd(2'd2, v); chk(v[0] == 1'b1, "R5 NACK sampled", v[0], 1);
      wr(2'd2, 8'hC0);
   endtask

   task automatic t_rx();
      logic [7:0] v;
      wr(2'd0, 8'hE0);
      byte_xfer(2, 8'h3C, 8'h00);
      rd(2'd1, v); chk(v == 8'h3C, "R6 received byte", v, 8'h3C);
      chk(cap[0] == 1'b0, "R6 ACK driven", cap[0], 0);
      wr(2'd2, 8'hC0);
      wr(2'd0, 8'hE8);
      byte_xfer(2, 8'hC3, 8'h00);
      rd(2'd1, v); chk(v == 8'hC3, "R6 received byte 2", v, 8'hC3);
      chk(cap[0] == 1'b1, "R6 NACK left released", cap[0], 1);
      wr(2'd2, 8'hC0);
   endtask

   task automatic t_rstart();
      logic [7:0] v;
      int s0 = start_cnt, p0 = stop_cnt;
      mode = 0;
      wr(2'd0, 8'hB4); idle(60);
      chk(start_cnt == s0 + 1 && stop_cnt == p0, "R7 repeated START only",
          start_cnt - s0, 1);
      rd(2'd0, v); chk(v == 8'hB0, "R7 request bit reads 0", v, 8'hB0);
   endtask

   task automatic t_stop();
      logic [7:0] v;
      int p0 = stop_cnt;
      wr(2'd0, 8'h90); idle(60);
      chk(stop_cnt == p0 + 1, "R4 one STOP", stop_cnt - p0, 1);
      rd(2'd0, v); chk(v == 8'h90, "R4 master cleared", v, 8'h90);
      chk(!scl_oe && !sda_oe, "R4 lines released", {scl_oe, sda_oe}, 0);
   endtask

   task automatic t_bad_rstart();
      logic [7:0] v;
      int s0 = start_cnt;
      wr(2'd0, 8'h94); idle(60);
      rd(2'd2, v); chk(v[6] == 1'b1, "R8 arb flag on bad request", v, 8'h40);
      chk(start_cnt == s0, "R8 no START", start_cnt - s0, 0);
      wr(2'd2, 8'hC0);
   endtask

   task automatic t_arb();
      logic [7:0] v;
      int p0;
      mode = 0;
      wr(2'd0, 8'hF0); idle(40);
      p0 = stop_cnt;
      mode = 3; bcf = 0;
      wr(2'd1, 8'hFF);
      idle(100);
      rd(2'd0, v); chk(v == 8'hD0, "R9 master cleared", v, 8'hD0);
      rd(2'd2, v); chk(v[6] == 1'b1, "R9 arb flag", v, 8'h40);
      chk(stop_cnt == p0, "R9 no STOP", stop_cnt - p0, 0);
      chk(!scl_oe && !sda_oe, "R9 lines released", {scl_oe, sda_oe}, 0);
      chk(irq == 1'b1, "R10 irq on arbitration loss", irq, 1);
      mode = 0;
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_disabled();
      t_start();
      t_tx();
      t_rx();
      t_rstart();
      t_stop();
      t_bad_rstart();
      t_arb();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #1500000;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule